// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block holds a small ring of buffered stores in program order and answers load queries that may pick up bytes from older stores still waiting in the ring. Each store entry keeps a virtual address, a physical address, an 8-bit byte-lane mask, lane-aligned data and a ready flag for that data. A store can enter without its data. The data is then written later through a separate port, using the entry index. Stores leave from the oldest end when they retire. A flush empties the ring and drops any lookups still in flight.

A load gives its virtual address, its physical address, its byte-lane mask and a vector that marks which ring entries are older than the load. The caller computes this vector ahead of time. One cycle after the query, the block returns a fast lane-coverage mask and a fast "must wait" flag. One cycle after that, it returns the final per-lane forward-valid bits and data bytes, the wait flag, the index of the blocking store, and a flag that is raised when the virtual and physical lookups disagree.

Top module: `stld_fwd_unit`

## Requirements
- R1: A store's lane mask comes from its size code shifted left by physical address bits [2:0]. The base masks are 0x01 for code 0 (byte), 0x03 for code 1 (half), 0x0F for code 2 (word) and 0xFF for code 3 (double).
- R2: Store data is copied across the 64-bit lane word by size: a byte is repeated 8 times, a half 4 times and a word twice, and a double is stored unchanged. Lane k holds bits [8k+7:8k].
- R3: A query accepted on a clock edge gives `s1_valid` and `s1_fwd_mask` after that edge, and `s2_valid`, `s2_fwd_mask` and `s2_fwd_data` after the following edge.
- R4: When several older stores cover the same lane, the lane comes from the youngest of them. Age is counted from the oldest live entry.
- R5: An entry takes part only if all of these hold: it is live, its bit is set in `ld_older`, its address above bit 2 equals the load's, and its lane mask overlaps `ld_mask`. Only the lanes in both masks are forwarded.
- R6: If the youngest matching store for any requested lane has no data, both `s1_data_wait` and `s2_data_wait` are raised. `s2_wait_idx` gives the youngest matching older entry that lacks data, and that lane is not marked forward-valid.
- R7: `s2_addr_conflict` is raised when the set of entries matched by virtual address differs from the set matched by physical address.
- R8: A data write to an entry, copied by that entry's size, makes the entry forwardable for later queries.
- R9: A retire removes the oldest live entry, so that entry no longer forwards.
- R10: `flush` empties the ring and clears both response stages on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty ring, drop in-flight lookups |
| st_push | input | 1 | Append a store |
| st_size | input | 2 | Store size code |
| st_vaddr | input | VA_W | Store virtual address |
| st_paddr | input | PA_W | Store physical address |
| st_data | input | 64 | Store raw data |
| st_data_ok | input | 1 | Data is present at append |
| sd_write | input | 1 | Late data write |
| sd_idx | input | IDX_W | Entry receiving late data |
| sd_data | input | 64 | Late raw data |
| st_retire | input | 1 | Release the oldest entry |
| ld_req | input | 1 | Load query valid |
| ld_vaddr | input | VA_W | Load virtual address |
| ld_paddr | input | PA_W | Load physical address |
| ld_mask | input | 8 | Load lane mask |
| ld_older | input | DEPTH | Entries older than the load |
| s1_valid | output | 1 | Stage-1 response valid |
| s1_fwd_mask | output | 8 | Lanes covered by older matching stores |
| s1_data_wait | output | 1 | Fast wait flag |
| s2_valid | output | 1 | Stage-2 response valid |
| s2_fwd_mask | output | 8 | Lanes forwarded with valid data |
| s2_fwd_data | output | 64 | Forwarded lane bytes |
| s2_data_wait | output | 1 | Load must wait for store data |
| s2_wait_idx | output | IDX_W | Youngest matching entry lacking data |
| s2_addr_conflict | output | 1 | Virtual and physical matches disagree |

## Verification
A wrong age pointer or a stale live bit in the ring shows up in the stage-2 data. A lane would then carry an older store's byte, or a retired store's byte, two edges after the query. A lost ready flag shows up as a wait flag at stage 1, one edge after the query. The directed cases layer stores of different sizes over one word. They also vary the older-entry vector, so that a selection error changes the bytes observed.

// File: rtl/stld_fwd_pkg.sv
`timescale 1ns/1ps
package stld_fwd_pkg;
   localparam int LANES = 8;
   localparam int WORD_W = 64;

   function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [2:0] off);
      logic [LANES-1:0] base;
      case (sz)
         2'd0:    base = 8'h01;
         2'd1:    base = 8'h03;
         2'd2:    base = 8'h0F;
         default: base = 8'hFF;
      endcase
      return base << off;
   endfunction

   function automatic logic [WORD_W-1:0] lane_copy(input logic [WORD_W-1:0] d, input logic [1:0] sz);
      case (sz)
         2'd0:    return {8{d[7:0]}};
         2'd1:    return {4{d[15:0]}};
         2'd2:    return {2{d[31:0]}};
         default: return d;
      endcase
   endfunction
endpackage

// File: rtl/stld_sq_store.sv
`timescale 1ns/1ps
module stld_sq_store
   import stld_fwd_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int VA_W  = 40,
   parameter int PA_W  = 36,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int VT_W  = VA_W - 3,
   localparam int PT_W  = PA_W - 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          enq,
   input  logic [1:0]                    enq_size,
   input  logic [VA_W-1:0]               enq_va,
   input  logic [PA_W-1:0]               enq_pa,
   input  logic [WORD_W-1:0]             enq_data,
   input  logic                          enq_ok,
   input  logic                          dw_vld,
   input  logic [IDX_W-1:0]              dw_idx,
   input  logic [WORD_W-1:0]             dw_data,
   input  logic                          deq,
   output logic [DEPTH-1:0]              e_live,
   output logic [DEPTH-1:0][VT_W-1:0]    e_vtag,
   output logic [DEPTH-1:0][PT_W-1:0]    e_ptag,
   output logic [DEPTH-1:0][LANES-1:0]   e_mask,
   output logic [DEPTH-1:0][WORD_W-1:0]  e_data,
   output logic [DEPTH-1:0]              e_ok,
   output logic [IDX_W-1:0]              head
);
   logic [IDX_W-1:0]           tail;
   logic [DEPTH-1:0][1:0]      e_size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_live <= '0;
         e_ok   <= '0;
         head   <= '0;
         tail   <= '0;
      end else if (flush) begin
         e_live <= '0;
         e_ok   <= '0;
         head   <= '0;
         tail   <= '0;
      end else begin
         if (deq) begin
            e_live[head] <= 1'b0;
            head         <= head + 1'b1;
         end
         if (dw_vld) e_ok[dw_idx] <= 1'b1;
         if (enq) begin
            e_live[tail] <= 1'b1;
            e_ok[tail]   <= enq_ok;
            tail         <= tail + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (dw_vld) e_data[dw_idx] <= lane_copy(dw_data, e_size[dw_idx]);
      if (enq) begin
         e_vtag[tail] <= enq_va[VA_W-1:3];
         e_ptag[tail] <= enq_pa[PA_W-1:3];
         e_mask[tail] <= lane_mask(enq_size, enq_pa[2:0]);
         e_size[tail] <= enq_size;
         e_data[tail] <= lane_copy(enq_data, enq_size);
      end
   end

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (e_live == '0));
   // R9
   retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deq && !enq && !flush) |=> !e_live[$past(head)]);
endmodule

// File: rtl/stld_fwd_match.sv
`timescale 1ns/1ps
module stld_fwd_match
   import stld_fwd_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int VA_W  = 40,
   parameter int PA_W  = 36,
   localparam int VT_W = VA_W - 3,
   localparam int PT_W = PA_W - 3
) (
   input  logic [DEPTH-1:0]              e_live,
   input  logic [DEPTH-1:0][VT_W-1:0]    e_vtag,
   input  logic [DEPTH-1:0][PT_W-1:0]    e_ptag,
   input  logic [DEPTH-1:0][LANES-1:0]   e_mask,
   input  logic [VA_W-1:0]               q_va,
   input  logic [PA_W-1:0]               q_pa,
   input  logic [LANES-1:0]              q_mask,
   input  logic [DEPTH-1:0]              q_older,
   output logic [DEPTH-1:0]              vhit,
   output logic [DEPTH-1:0][LANES-1:0]   plane
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic             cand;
      logic [LANES-1:0] ovl;
      assign cand = e_live[g] & q_older[g];
      assign ovl  = e_mask[g] & q_mask;
      assign vhit[g]  = cand && (e_vtag[g] == q_va[VA_W-1:3]) && (|ovl);
      assign plane[g] = (cand && (e_ptag[g] == q_pa[PA_W-1:3])) ? ovl : '0;
   end
endmodule

// File: rtl/stld_fwd_select.sv
`timescale 1ns/1ps
module stld_fwd_select
   import stld_fwd_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0]              head,
   input  logic [DEPTH-1:0][LANES-1:0]   plane,
   input  logic [DEPTH-1:0]              ok,
   input  logic [DEPTH-1:0][WORD_W-1:0]  e_data,
   output logic [LANES-1:0]              sel_mask,
   output logic [WORD_W-1:0]             sel_data,
   output logic                          sel_wait,
   output logic [IDX_W-1:0]              sel_idx
);
   always_comb begin
      logic [IDX_W-1:0] idx;
      idx      = '0;
      sel_mask = '0;
      sel_data = '0;
      sel_wait = 1'b0;
      sel_idx  = '0;
      // oldest first, so younger entries overwrite
      for (int k = 0; k < DEPTH; k++) begin
         idx = head + IDX_W'(k);
         for (int b = 0; b < LANES; b++) begin
            if (plane[idx][b]) begin
               sel_mask[b]        = ok[idx];
               sel_data[8*b +: 8] = e_data[idx][8*b +: 8];
            end
         end
         if ((|plane[idx]) && !ok[idx]) begin
            sel_wait = 1'b1;
            sel_idx  = idx;
         end
      end
   end
endmodule

// File: rtl/stld_fwd_unit.sv
`timescale 1ns/1ps
module stld_fwd_unit
   import stld_fwd_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int VA_W  = 40,
   parameter int PA_W  = 36,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              st_push,
   input  logic [1:0]        st_size,
   input  logic [VA_W-1:0]   st_vaddr,
   input  logic [PA_W-1:0]   st_paddr,
   input  logic [63:0]       st_data,
   input  logic              st_data_ok,
   input  logic              sd_write,
   input  logic [IDX_W-1:0]  sd_idx,
   input  logic [63:0]       sd_data,
   input  logic              st_retire,
   input  logic              ld_req,
   input  logic [VA_W-1:0]   ld_vaddr,
   input  logic [PA_W-1:0]   ld_paddr,
   input  logic [7:0]        ld_mask,
   input  logic [DEPTH-1:0]  ld_older,
   output logic              s1_valid,
   output logic [7:0]        s1_fwd_mask,
   output logic              s1_data_wait,
   output logic              s2_valid,
   output logic [7:0]        s2_fwd_mask,
   output logic [63:0]       s2_fwd_data,
   output logic              s2_data_wait,
   output logic [IDX_W-1:0]  s2_wait_idx,
   output logic              s2_addr_conflict
);
   localparam int VT_W = VA_W - 3;
   localparam int PT_W = PA_W - 3;

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (VA_W < 4 || PA_W < 4) begin : g_bad_addr
      $error("address widths must exceed the lane offset");
   end

   logic [DEPTH-1:0]              e_live, e_ok, vhit;
   logic [DEPTH-1:0][VT_W-1:0]    e_vtag;
   logic [DEPTH-1:0][PT_W-1:0]    e_ptag;
   logic [DEPTH-1:0][LANES-1:0]   e_mask, plane;
   logic [DEPTH-1:0][WORD_W-1:0]  e_data;
   logic [IDX_W-1:0]              head;

   stld_sq_store #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .enq(st_push), .enq_size(st_size), .enq_va(st_vaddr), .enq_pa(st_paddr),
      .enq_data(st_data), .enq_ok(st_data_ok),
      .dw_vld(sd_write), .dw_idx(sd_idx), .dw_data(sd_data), .deq(st_retire),
      .e_live(e_live), .e_vtag(e_vtag), .e_ptag(e_ptag), .e_mask(e_mask),
      .e_data(e_data), .e_ok(e_ok), .head(head));

   stld_fwd_match #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W)) u_match (
      .e_live(e_live), .e_vtag(e_vtag), .e_ptag(e_ptag), .e_mask(e_mask),
      .q_va(ld_vaddr), .q_pa(ld_paddr), .q_mask(ld_mask), .q_older(ld_older),
      .vhit(vhit), .plane(plane));

   // stage 1 snapshot
   logic                          r1_vld;
   logic [DEPTH-1:0]              r1_vhit, r1_ok;
   logic [DEPTH-1:0][LANES-1:0]   r1_plane;
   logic [IDX_W-1:0]              r1_head;
   logic [DEPTH-1:0]              r1_phit;
   logic [LANES-1:0]              r1_cover;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      r1_vld <= 1'b0;
      else if (flush)  r1_vld <= 1'b0;
      else             r1_vld <= ld_req;
   end

   always_ff @(posedge clk) begin
      if (ld_req) begin
         r1_vhit  <= vhit;
         r1_plane <= plane;
         r1_ok    <= e_ok;
         r1_head  <= head;
      end
   end

   always_comb begin
      r1_cover = '0;
      for (int i = 0; i < DEPTH; i++) begin
         r1_phit[i] = |r1_plane[i];
         r1_cover   = r1_cover | r1_plane[i];
      end
   end

   assign s1_valid     = r1_vld;
   assign s1_fwd_mask  = r1_vld ? r1_cover : '0;
   assign s1_data_wait = r1_vld && (|(r1_phit & ~r1_ok));

   logic [LANES-1:0]  sel_mask;
   logic [WORD_W-1:0] sel_data;
   logic              sel_wait;
   logic [IDX_W-1:0]  sel_idx;

   stld_fwd_select #(.DEPTH(DEPTH)) u_select (
      .head(r1_head), .plane(r1_plane), .ok(r1_ok), .e_data(e_data),
      .sel_mask(sel_mask), .sel_data(sel_data), .sel_wait(sel_wait), .sel_idx(sel_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid         <= 1'b0;
         s2_fwd_mask      <= '0;
         s2_fwd_data      <= '0;
         s2_data_wait     <= 1'b0;
         s2_wait_idx      <= '0;
         s2_addr_conflict <= 1'b0;
      end else begin
         s2_valid         <= r1_vld && !flush;
         s2_fwd_mask      <= (r1_vld && !flush) ? sel_mask : '0;
         s2_fwd_data      <= sel_data;
         s2_data_wait     <= r1_vld && !flush && sel_wait;
         s2_wait_idx      <= sel_idx;
         s2_addr_conflict <= r1_vld && !flush && (r1_vhit != r1_phit);
      end
   end

   // R3
   stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2_valid |-> $past(s1_valid));
   // R3
   mask_within_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2_valid |-> ((s2_fwd_mask & ~$past(s1_fwd_mask)) == '0));
   // R6
   wait_has_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2_data_wait |-> $past(s1_data_wait));
   // R10
   flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!s1_valid && !s2_valid));
endmodule

// File: tb/test_stld_fwd_unit.sv
`timescale 1ns/1ps
module test_stld_fwd_unit;
   localparam int D = 8;
   localparam int VA = 40;
   localparam int PA = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 0, st_push = 0, st_data_ok = 0, sd_write = 0, st_retire = 0, ld_req = 0;
   logic [1:0] st_size = 0;
   logic [VA-1:0] st_vaddr = 0, ld_vaddr = 0;
   logic [PA-1:0] st_paddr = 0, ld_paddr = 0;
   logic [63:0] st_data = 0, sd_data = 0;
   logic [2:0] sd_idx = 0;
   logic [7:0] ld_mask = 0;
   logic [D-1:0] ld_older = 0;
   logic s1_valid, s1_data_wait, s2_valid, s2_data_wait, s2_addr_conflict;
   logic [7:0] s1_fwd_mask, s2_fwd_mask;
   logic [63:0] s2_fwd_data;
   logic [2:0] s2_wait_idx;

   int total = 0, bad = 0;
   bit finished = 0;

   // captured responses
   logic c1_v, c1_w, c2_v, c2_w, c2_c;
   logic [7:0] c1_m, c2_m;
   logic [63:0] c2_d;
   logic [2:0] c2_i;

   always #4 clk = ~clk;

   stld_fwd_unit #(.DEPTH(D), .VA_W(VA), .PA_W(PA)) i_stld_fwd_unit (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .st_push(st_push), .st_size(st_size), .st_vaddr(st_vaddr), .st_paddr(st_paddr),
      .st_data(st_data), .st_data_ok(st_data_ok),
      .sd_write(sd_write), .sd_idx(sd_idx), .sd_data(sd_data), .st_retire(st_retire),
      .ld_req(ld_req), .ld_vaddr(ld_vaddr), .ld_paddr(ld_paddr), .ld_mask(ld_mask),
      .ld_older(ld_older),
      .s1_valid(s1_valid), .s1_fwd_mask(s1_fwd_mask), .s1_data_wait(s1_data_wait),
      .s2_valid(s2_valid), .s2_fwd_mask(s2_fwd_mask), .s2_fwd_data(s2_fwd_data),
      .s2_data_wait(s2_data_wait), .s2_wait_idx(s2_wait_idx),
      .s2_addr_conflict(s2_addr_conflict));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lanes(input logic [7:0] m);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = {8{m[b]}};
      return r;
   endfunction

   task automatic push(input logic [1:0] sz, input logic [VA-1:0] va, input logic [PA-1:0] pa,
                       input logic [63:0] d, input logic ok);
      @(negedge clk);
      st_push = 1; st_size = sz; st_vaddr = va; st_paddr = pa; st_data = d; st_data_ok = ok;
      @(negedge clk);
      st_push = 0;
   endtask

   task automatic query(input logic [VA-1:0] va, input logic [PA-1:0] pa,
                        input logic [7:0] m, input logic [D-1:0] old);
      @(negedge clk);
      ld_req = 1; ld_vaddr = va; ld_paddr = pa; ld_mask = m; ld_older = old;
      @(negedge clk);
      ld_req = 0;
      c1_v = s1_valid; c1_m = s1_fwd_mask; c1_w = s1_data_wait;
      @(negedge clk);
      c2_v = s2_valid; c2_m = s2_fwd_mask; c2_d = s2_fwd_data & lanes(s2_fwd_mask);
      c2_w = s2_data_wait; c2_i = s2_wait_idx; c2_c = s2_addr_conflict;
   endtask

   task automatic t_reset;
      check("R3 reset s1_valid", s1_valid, 0);
      check("R3 reset s2_valid", s2_valid, 0);
      check("R6 reset wait", s2_data_wait, 0);
      check("R7 reset conflict", s2_addr_conflict, 0);
   endtask

   task automatic t_sizes;
      push(2'd0, 40'h103, 36'h103, 64'hAB, 1);            // entry 0
      query(40'h100, 36'h100, 8'hFF, 8'h01);
      check("R3 s1 valid", c1_v, 1);
      check("R1 byte fast mask", c1_m, 8'h08);
      check("R3 s2 valid", c2_v, 1);
      check("R1 byte mask", c2_m, 8'h08);
      check("R2 byte copy", c2_d, 64'h0000_0000_AB00_0000);
      push(2'd1, 40'h106, 36'h106, 64'h1234, 1);          // entry 1
      query(40'h100, 36'h100, 8'hFF, 8'h03);
      check("R1 half mask", c2_m, 8'hC8);
      check("R2 half copy", c2_d, 64'h1234_0000_AB00_0000);
   endtask

   task automatic t_youngest;
      push(2'd2, 40'h104, 36'h104, 64'hDEADBEEF, 1);      // entry 2
      query(40'h100, 36'h100, 8'hFF, 8'h07);
      check("R4 youngest mask", c2_m, 8'hF8);
      check("R4 youngest data", c2_d, 64'hDEAD_BEEF_AB00_0000);
      query(40'h100, 36'h100, 8'hFF, 8'h03);
      check("R4 younger excluded", c2_d, 64'h1234_0000_AB00_0000);
   endtask

   task automatic t_filter;
      query(40'h100, 36'h100, 8'hFF, 8'h00);
      check("R5 none older", c2_m, 8'h00);
      check("R5 none older fast", c1_m, 8'h00);
      query(40'h100, 36'h100, 8'h0F, 8'h07);
      check("R5 load mask", c2_m, 8'h08);
      query(40'h108, 36'h108, 8'hFF, 8'h07);
      check("R5 other word", c2_m, 8'h00);
      check("R7 other word conflict", c2_c, 0);
   endtask

   task automatic t_wait;
      push(2'd3, 40'h200, 36'h200, 64'h0, 0);             // entry 3, no data
      query(40'h200, 36'h200, 8'hFF, 8'h0F);
      check("R6 fast wait", c1_w, 1);
      check("R6 wait", c2_w, 1);
      check("R6 wait idx", c2_i, 3);
      check("R6 no lanes", c2_m, 8'h00);
      @(negedge clk);
      sd_write = 1; sd_idx = 3; sd_data = 64'h1122334455667788;
      @(negedge clk);
      sd_write = 0;
      query(40'h200, 36'h200, 8'hFF, 8'h0F);
      check("R8 wait gone", c2_w, 0);
      check("R8 lanes", c2_m, 8'hFF);
      check("R8 data", c2_d, 64'h1122334455667788);
   endtask

   task automatic t_conflict;
      push(2'd0, 40'h300, 36'h400, 64'h5A, 1);            // entry 4
      query(40'h300, 36'h500, 8'h01, 8'h1F);
      check("R7 conflict", c2_c, 1);
      check("R7 conflict lanes", c2_m, 8'h00);
      query(40'h300, 36'h400, 8'h01, 8'h1F);
      check("R7 agree", c2_c, 0);
      check("R7 agree data", c2_d, 64'h5A);
   endtask

   task automatic t_retire;
      @(negedge clk);
      st_retire = 1;
      @(negedge clk);
      st_retire = 0;
      query(40'h100, 36'h100, 8'hFF, 8'h07);
      check("R9 retired mask", c2_m, 8'hF0);
      check("R9 retired data", c2_d, 64'hDEAD_BEEF_0000_0000);
   endtask

   task automatic t_flush;
      @(negedge clk);
      ld_req = 1; ld_vaddr = 40'h104; ld_paddr = 36'h104; ld_mask = 8'hFF; ld_older = 8'h1F;
      @(negedge clk);
      ld_req = 0; flush = 1;
      @(negedge clk);
      flush = 0;
      check("R10 s1 dropped", s1_valid, 0);
      check("R10 s2 dropped", s2_valid, 0);
      query(40'h104, 36'h104, 8'hFF, 8'h1F);
      check("R10 empty valid", c2_v, 1);
      check("R10 empty mask", c2_m, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_sizes();
      t_youngest();
      t_filter();
      t_wait();
      t_conflict();
      t_retire();
      t_flush();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule